// File: doc/BRIEF.md
# Coprocessor Register File with Host Transfer Sequencing

This block holds the architectural state of a coprocessor: a bank of sixteen 64-bit registers, each made of an upper and a lower 32-bit half. A host core reaches the bank in two ways. Single-word register moves write or read one half directly. Memory load and store beats carry one word per cycle between the bus and the bank. The host presents one command per cycle. Each command has a 3-bit kind, the 32-bit instruction word that caused it, a 32-bit data word and the current bus endianness.

The block decodes the register index and the sub-opcode from the instruction word. It picks the half that each kind of access uses. For two-word transfers it keeps a beat counter, so the host knows whether another beat must follow. Instruction bit 8 separates the two operand groups. When the bit is clear the access uses the single-precision group, whose values live in the upper half. When it is set the access uses the integer group, whose 32-bit values live in the lower half.

Every response is registered. It appears on the outputs one clock after the command and lasts exactly one cycle.

Top module: `cp_regfile_xfer`

## Requirements
- R1: After reset every half of every register reads as zero, and beat_done, beat_more and illegal are low until the first command.
- R2: A move-to command (kind 1) writes wdata into the register selected by instruction bits 19:16. Sub-opcode 0 (bits 7:5) selects the lower half and sub-opcode 1 the upper half. The other half keeps its value.
- R3: A move-from command (kind 2) reads the same half that the same sub-opcode selects. It presents the half on rdata one clock later, together with beat_done.
- R4: Sub-opcode 2 with instruction bit 8 clear is a single-precision move and uses the upper half for both move-to and move-from.
- R5: A load beat (kind 3) with instruction bit 22 set is one beat of a two-word transfer into the register selected by bits 15:12. When big_endian is 1 the first beat fills the upper half and the second beat the lower half. When big_endian is 0 the order is reversed.
- R6: A store beat (kind 4) with bit 22 set returns halves on rdata in the same endianness order as R5. The first beat of any two-word transfer answers beat_more and the second answers beat_done.
- R7: A one-word load or store (bit 22 clear) with bit 8 clear uses the upper half, and the lower half is left unchanged.
- R8: A one-word load with bit 8 set writes the lower half and fills the upper half with copies of data bit 31. A one-word store with bit 8 set returns the lower half.
- R9: A start command (kind 0) answers beat_done and resets the beat counter, so the next two-word beat counts as a first beat. It changes no register.
- R10: A command kind of 5 to 7, or a move sub-opcode other than 0, 1 or 2 (2 only with bit 8 clear), raises illegal for one cycle. It answers neither beat_done nor beat_more, and it changes no register and no beat count.
- R11: beat_done and beat_more are never high together, and no response appears in a cycle that does not follow a valid command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_kind | input | 3 | 0 start, 1 move-to, 2 move-from, 3 load beat, 4 store beat |
| insn | input | 32 | Instruction word carrying the register fields and sub-opcode |
| wdata | input | 32 | Data word for move-to and load beats |
| big_endian | input | 1 | Bus endianness for two-word transfers |
| rdata | output | 32 | Half read by the last move-from or store beat |
| beat_done | output | 1 | The command of the previous cycle finished its transfer |
| beat_more | output | 1 | Another beat of a two-word transfer is expected |
| illegal | output | 1 | The command of the previous cycle was unsupported |

## Verification
Suppose the beat counter holds the wrong phase. The next two-word beat then answers beat_more where beat_done was due, and it lands in the opposite half. Both faults are visible one cycle after that beat. The bench reads the halves back by move-from, so a corrupted or unexpectedly altered half shows on rdata one cycle after the read-back command. This covers the wrong half order, a missing sign fill, and a write by an illegal or start command. Each read-back follows directly after the stimulus, so a fault is caught before another command can mask it.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int NREGS  = 16;
  localparam int HALF_W = 32;
  localparam int IDX_W  = $clog2(NREGS);

  // Instruction field positions; these are decoded by the host side too
  localparam int SRC1_LSB = 16;
  localparam int DEST_LSB = 12;
  localparam int SUB_LSB  = 5;
  localparam int PAIR_BIT = 22;
  localparam int GRP_BIT  = 8;

  typedef enum logic [2:0] {
    CMD_START     = 3'd0,
    CMD_MOVE_TO   = 3'd1,
    CMD_MOVE_FROM = 3'd2,
    CMD_LOAD      = 3'd3,
    CMD_STORE     = 3'd4
  } cmd_e;

  typedef struct packed {
    logic             wr_en;
    logic             rd_en;
    logic             use_hi;
    logic             sext;
    logic [IDX_W-1:0] idx;
    logic             advance;
    logic             clear;
    logic             resp_done;
    logic             resp_more;
    logic             bad;
  } op_t;

  // Half hit by the current beat of a two-word transfer
  function automatic logic pair_half_hi(input logic be, input logic phase);
    return be ^ phase;
  endfunction

  // Upper-half fill for a sign-extending integer load
  function automatic logic [HALF_W-1:0] sext_fill(input logic [HALF_W-1:0] w);
    return {HALF_W{w[HALF_W-1]}};
  endfunction
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
(
  input  logic [2:0]       cmd_kind,
  input  logic [IDX_W-1:0] src1_idx,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic [2:0]       sub_op,
  input  logic             pair,
  input  logic             int_grp,
  input  logic             big_endian,
  input  logic             phase,
  output op_t              op
);
  logic sel_hi;
  logic sel_bad;

  always_comb begin
    sel_hi  = 1'b0;
    sel_bad = 1'b0;
    case (sub_op)
      3'd0:    sel_hi = 1'b0;
      3'd1:    sel_hi = 1'b1;
      3'd2:    begin sel_hi = 1'b1; sel_bad = int_grp; end
      default: sel_bad = 1'b1;
    endcase
  end

  always_comb begin
    op = '0;
    case (cmd_kind)
      CMD_START: begin
        op.clear     = 1'b1;
        op.resp_done = 1'b1;
      end
      CMD_MOVE_TO, CMD_MOVE_FROM: begin
        op.idx    = src1_idx;
        op.use_hi = sel_hi;
        if (sel_bad) begin
          op.bad = 1'b1;
        end else begin
          op.wr_en     = (cmd_kind == CMD_MOVE_TO);
          op.rd_en     = (cmd_kind == CMD_MOVE_FROM);
          op.resp_done = 1'b1;
        end
      end
      CMD_LOAD, CMD_STORE: begin
        op.idx   = dest_idx;
        op.wr_en = (cmd_kind == CMD_LOAD);
        op.rd_en = (cmd_kind == CMD_STORE);
        if (pair) begin
          op.use_hi    = pair_half_hi(big_endian, phase);
          op.advance   = 1'b1;
          op.resp_done = phase;
          op.resp_more = ~phase;
        end else begin
          op.use_hi    = ~int_grp;
          op.sext      = int_grp & (cmd_kind == CMD_LOAD);
          op.resp_done = 1'b1;
        end
      end
      default: op.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cpx_beat_seq.sv
module cpx_beat_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= 1'b0;
    else if (clear)   phase <= 1'b0;
    else if (advance) phase <= ~phase;
  end
endmodule

// File: rtl/cpx_bank.sv
module cpx_bank
  import cpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic              wr_sext,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] wdata,
  input  logic              rd_hi,
  output logic [HALF_W-1:0] rd_word
);
  logic [HALF_W-1:0] hi_q [NREGS];
  logic [HALF_W-1:0] lo_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (hit) begin
        if (wr_hi) begin
          hi_q[g] <= wdata;
        end else begin
          lo_q[g] <= wdata;
          if (wr_sext) hi_q[g] <= sext_fill(wdata);
        end
      end
    end
  end

  assign rd_word = rd_hi ? hi_q[idx] : lo_q[idx];
endmodule

// File: rtl/cp_regfile_xfer.sv
module cp_regfile_xfer
  import cpx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_kind,
  input  logic [31:0] insn,
  input  logic [31:0] wdata,
  input  logic        big_endian,
  output logic [31:0] rdata,
  output logic        beat_done,
  output logic        beat_more,
  output logic        illegal
);
  op_t         op;
  logic        seq_phase;
  logic        fire;
  logic        pair_beat;
  logic [31:0] rd_word;
  logic        unused_bits;

  assign unused_bits = ^{insn[31:23], insn[21:20], insn[11:9], insn[4:0]};

  cpx_decode u_dec (
    .cmd_kind   (cmd_kind),
    .src1_idx   (insn[SRC1_LSB +: IDX_W]),
    .dest_idx   (insn[DEST_LSB +: IDX_W]),
    .sub_op     (insn[SUB_LSB +: 3]),
    .pair       (insn[PAIR_BIT]),
    .int_grp    (insn[GRP_BIT]),
    .big_endian (big_endian),
    .phase      (seq_phase),
    .op         (op)
  );

  assign fire      = cmd_valid && !op.bad;
  assign pair_beat = fire && op.advance;

  cpx_beat_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (fire && op.clear),
    .advance (pair_beat),
    .phase   (seq_phase)
  );

  cpx_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire && op.wr_en),
    .wr_hi   (op.use_hi),
    .wr_sext (op.sext),
    .idx     (op.idx),
    .wdata   (wdata),
    .rd_hi   (op.use_hi),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata     <= '0;
      beat_done <= 1'b0;
      beat_more <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      beat_done <= fire && op.resp_done;
      beat_more <= fire && op.resp_more;
      illegal   <= cmd_valid && op.bad;
      if (fire && op.rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/cpx_regfile_chk.sv
module cpx_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       beat_done,
  input logic       beat_more,
  input logic       illegal,
  input logic       seq_phase,
  input logic       pair_beat
);
  // R11
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_done && beat_more));

  // R11
  resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done || beat_more || illegal) |-> $past(cmd_valid));

  // R9
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd0) |=> (beat_done && !seq_phase));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!beat_done && !beat_more));

  // R6
  first_beat_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_more |-> seq_phase);

  // R6
  second_beat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_beat && seq_phase) |=> (beat_done && !seq_phase));
endmodule

bind cp_regfile_xfer cpx_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .beat_done (beat_done),
  .beat_more (beat_more),
  .illegal   (illegal),
  .seq_phase (seq_phase),
  .pair_beat (pair_beat)
);

// File: tb/cp_regfile_xfer_test.sv
`timescale 1ns/1ps
module cp_regfile_xfer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_kind = '0;
  logic [31:0] insn = '0;
  logic [31:0] wdata = '0;
  logic        big_endian = 1'b0;
  logic [31:0] rdata;
  logic        beat_done, beat_more, illegal;

  int checks = 0;
  int fails  = 0;

  // Sampled response of the last issued command
  logic [31:0] r_data;
  logic        r_done, r_more, r_ill;

  always #4 clk = ~clk;

  cp_regfile_xfer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .insn(insn), .wdata(wdata), .big_endian(big_endian), .rdata(rdata),
    .beat_done(beat_done), .beat_more(beat_more), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input logic [2:0] sub, input logic [3:0] s1,
                                     input logic [3:0] d, input logic grp,
                                     input logic pair);
    logic [31:0] w = '0;
    w[7:5]   = sub;
    w[19:16] = s1;
    w[15:12] = d;
    w[8]     = grp;
    w[22]    = pair;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [31:0] i,
                       input logic [31:0] d, input logic be);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; insn = i; wdata = d; big_endian = be;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_data = rdata; r_done = beat_done; r_more = beat_more; r_ill = illegal;
    // R11: never both
    if (r_done && r_more) chk("R11", 32'd1, 32'd0);
  endtask

  task automatic read_half(input logic [3:0] idx, input logic hi, output logic [31:0] v);
    issue(3'd2, mk({2'b00, hi}, idx, 4'd0, 1'b1, 1'b0), 32'd0, 1'b0);
    v = r_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 done", {31'd0, beat_done}, 32'd0);
    chk("R1 more", {31'd0, beat_more}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    read_half(4'd5, 1'b0, v); chk("R1 lo", v, 32'd0);
    read_half(4'd5, 1'b1, v); chk("R1 hi", v, 32'd0);
  endtask

  task automatic t_moves;
    logic [31:0] v;
    issue(3'd1, mk(3'd0, 4'd3, 4'd0, 1'b1, 1'b0), 32'hA5A5_0001, 1'b0);
    chk("R2 done", {31'd0, r_done}, 32'd1);
    issue(3'd1, mk(3'd1, 4'd3, 4'd0, 1'b1, 1'b0), 32'h1234_5678, 1'b0);
    read_half(4'd3, 1'b0, v); chk("R3 lo", v, 32'hA5A5_0001);
    chk("R3 done", {31'd0, r_done}, 32'd1);
    read_half(4'd3, 1'b1, v); chk("R3 hi", v, 32'h1234_5678);
    issue(3'd1, mk(3'd0, 4'd3, 4'd0, 1'b1, 1'b0), 32'h0000_00FF, 1'b0);
    read_half(4'd3, 1'b1, v); chk("R2 other half kept", v, 32'h1234_5678);
  endtask

  task automatic t_single_move;
    logic [31:0] v;
    issue(3'd1, mk(3'd2, 4'd7, 4'd0, 1'b0, 1'b0), 32'h3F80_0000, 1'b0);
    read_half(4'd7, 1'b1, v); chk("R4 upper", v, 32'h3F80_0000);
    read_half(4'd7, 1'b0, v); chk("R4 lower untouched", v, 32'd0);
    issue(3'd2, mk(3'd2, 4'd7, 4'd0, 1'b0, 1'b0), 32'd0, 1'b0);
    chk("R4 move-from", r_data, 32'h3F80_0000);
  endtask

  task automatic t_pair_load;
    logic [31:0] v;
    issue(3'd3, mk(3'd0, 4'd0, 4'd9, 1'b1, 1'b1), 32'hAAAA_0001, 1'b1);
    chk("R5 be first more", {30'd0, r_more, r_done}, 32'd2);
    issue(3'd3, mk(3'd0, 4'd0, 4'd9, 1'b1, 1'b1), 32'hBBBB_0002, 1'b1);
    chk("R5 be second done", {30'd0, r_more, r_done}, 32'd1);
    read_half(4'd9, 1'b1, v); chk("R5 be hi", v, 32'hAAAA_0001);
    read_half(4'd9, 1'b0, v); chk("R5 be lo", v, 32'hBBBB_0002);
    issue(3'd3, mk(3'd0, 4'd0, 4'd10, 1'b1, 1'b1), 32'hCCCC_0003, 1'b0);
    issue(3'd3, mk(3'd0, 4'd0, 4'd10, 1'b1, 1'b1), 32'hDDDD_0004, 1'b0);
    read_half(4'd10, 1'b0, v); chk("R5 le lo", v, 32'hCCCC_0003);
    read_half(4'd10, 1'b1, v); chk("R5 le hi", v, 32'hDDDD_0004);
  endtask

  task automatic t_pair_store;
    issue(3'd4, mk(3'd0, 4'd0, 4'd9, 1'b1, 1'b1), 32'd0, 1'b1);
    chk("R6 be first data", r_data, 32'hAAAA_0001);
    chk("R6 be first more", {30'd0, r_more, r_done}, 32'd2);
    issue(3'd4, mk(3'd0, 4'd0, 4'd9, 1'b1, 1'b1), 32'd0, 1'b1);
    chk("R6 be second data", r_data, 32'hBBBB_0002);
    chk("R6 be second done", {30'd0, r_more, r_done}, 32'd1);
    issue(3'd4, mk(3'd0, 4'd0, 4'd9, 1'b1, 1'b1), 32'd0, 1'b0);
    chk("R6 le first data", r_data, 32'hBBBB_0002);
    issue(3'd4, mk(3'd0, 4'd0, 4'd9, 1'b1, 1'b1), 32'd0, 1'b0);
    chk("R6 le second data", r_data, 32'hAAAA_0001);
  endtask

  task automatic t_single_word;
    logic [31:0] v;
    issue(3'd1, mk(3'd0, 4'd11, 4'd0, 1'b1, 1'b0), 32'h5555_1111, 1'b0);
    issue(3'd3, mk(3'd0, 4'd0, 4'd11, 1'b0, 1'b0), 32'h4049_0FDB, 1'b1);
    chk("R7 load done", {30'd0, r_more, r_done}, 32'd1);
    read_half(4'd11, 1'b1, v); chk("R7 upper", v, 32'h4049_0FDB);
    read_half(4'd11, 1'b0, v); chk("R7 lower kept", v, 32'h5555_1111);
    issue(3'd4, mk(3'd0, 4'd0, 4'd11, 1'b0, 1'b0), 32'd0, 1'b0);
    chk("R7 store upper", r_data, 32'h4049_0FDB);
  endtask

  task automatic t_int_word;
    logic [31:0] v;
    issue(3'd3, mk(3'd0, 4'd0, 4'd12, 1'b1, 1'b0), 32'h8000_0001, 1'b0);
    read_half(4'd12, 1'b0, v); chk("R8 neg lo", v, 32'h8000_0001);
    read_half(4'd12, 1'b1, v); chk("R8 neg fill", v, 32'hFFFF_FFFF);
    issue(3'd3, mk(3'd0, 4'd0, 4'd12, 1'b1, 1'b0), 32'h7FFF_FFFE, 1'b0);
    read_half(4'd12, 1'b1, v); chk("R8 pos fill", v, 32'h0000_0000);
    issue(3'd4, mk(3'd0, 4'd0, 4'd12, 1'b1, 1'b0), 32'd0, 1'b0);
    chk("R8 store lower", r_data, 32'h7FFF_FFFE);
  endtask

  task automatic t_start;
    logic [31:0] v;
    issue(3'd3, mk(3'd0, 4'd0, 4'd13, 1'b1, 1'b1), 32'h1111_AAAA, 1'b1);
    chk("R9 setup more", {31'd0, r_more}, 32'd1);
    issue(3'd0, mk(3'd0, 4'd13, 4'd13, 1'b1, 1'b1), 32'hFFFF_FFFF, 1'b1);
    chk("R9 start done", {30'd0, r_more, r_done}, 32'd1);
    issue(3'd3, mk(3'd0, 4'd0, 4'd13, 1'b1, 1'b1), 32'h2222_BBBB, 1'b1);
    chk("R9 restarted first", {30'd0, r_more, r_done}, 32'd2);
    read_half(4'd13, 1'b1, v); chk("R9 hi rewritten", v, 32'h2222_BBBB);
    read_half(4'd13, 1'b0, v); chk("R9 lo untouched", v, 32'd0);
    issue(3'd0, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    issue(3'd6, mk(3'd0, 4'd3, 4'd3, 1'b1, 1'b0), 32'hDEAD_BEEF, 1'b0);
    chk("R10 kind pulse", {29'd0, r_ill, r_more, r_done}, 32'd4);
    @(negedge clk);
    chk("R10 one cycle", {31'd0, illegal}, 32'd0);
    issue(3'd1, mk(3'd2, 4'd3, 4'd0, 1'b1, 1'b0), 32'hDEAD_BEEF, 1'b0);
    chk("R10 int sub2 pulse", {31'd0, r_ill}, 32'd1);
    issue(3'd1, mk(3'd5, 4'd3, 4'd0, 1'b0, 1'b0), 32'hDEAD_BEEF, 1'b0);
    chk("R10 sub5 pulse", {31'd0, r_ill}, 32'd1);
    read_half(4'd3, 1'b0, v); chk("R10 lo unchanged", v, 32'h0000_00FF);
    read_half(4'd3, 1'b1, v); chk("R10 hi unchanged", v, 32'h1234_5678);
    issue(3'd3, mk(3'd0, 4'd0, 4'd14, 1'b1, 1'b1), 32'h0F0F_0F0F, 1'b1);
    issue(3'd7, 32'd0, 32'd0, 1'b0);
    issue(3'd3, mk(3'd0, 4'd0, 4'd14, 1'b1, 1'b1), 32'hF0F0_F0F0, 1'b1);
    chk("R10 count kept", {30'd0, r_more, r_done}, 32'd1);
    read_half(4'd14, 1'b0, v); chk("R10 second half lo", v, 32'hF0F0_F0F0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R11 idle quiet", {29'd0, illegal, beat_more, beat_done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_moves;
    t_single_move;
    t_pair_load;
    t_pair_store;
    t_single_word;
    t_int_word;
    t_start;
    t_illegal;
    t_idle;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule